// File: doc/BRIEF.md
# Dispatch Predictor Read-Port Limiter

This block sits in the dispatch stage of an out-of-order core, beside the dependence predictor. Each cycle it receives an in-order dispatch group of up to `GRP_SLOTS` slots. Slot 0 holds the oldest instruction. Every slot carries three bits:

- a valid bit;
- a memory-operation bit;
- a hint bit, set when the compiler marked a memory operation as expected to be independent of in-flight stores.

A hinted memory operation skips the predictor lookup, so it needs no read port. An unhinted memory operation must query the predictor and takes one of `RD_PORTS` read ports.

For every slot the block decides two things: whether the slot dispatches this cycle, and whether it receives a predictor read port. When an unhinted memory operation finds every port taken, that slot and every younger slot are held. Dispatch never skips ahead, so program order is kept. The upstream stage re-presents the held slots the next cycle, with the oldest held slot moved to position 0. Each prediction completes within the cycle, so the port budget starts fresh every cycle. The block is purely combinational and holds no state.

Top module: `mdp_port_limiter`

## Requirements
- R1: Slot index 0 is the oldest slot. When no valid slot is an unhinted memory operation (valid=1, mem=1, hint=0), every valid slot is accepted, no stall bit is set and no port is granted.
- R2: At most `RD_PORTS` bits of `port_grant_o` are set in any cycle.
- R3: `port_grant_o[i]` is set exactly when slot i is a valid unhinted memory operation and `accept_o[i]` is set.
- R4: Non-memory slots and hinted memory slots use no read port and are never the lowest-index slot with `stall_o` set.
- R5: If the unhinted memory slots are counted from index 0 upward, the one numbered `RD_PORTS`+1 is the lowest index with `stall_o` set. `stall_o` is then set at that index and at every higher index. With `RD_PORTS` or fewer such slots, `stall_o` is all zero.
- R6: `accept_o[i]` equals the slot's valid bit ANDed with the inverse of `stall_o[i]`. An invalid slot is never accepted or granted and uses no port.
- R7: Outputs depend only on the current group. No port usage carries over from an earlier cycle, so the same group always gives the same result.
- R8: When held slots are re-presented with the oldest at index 0, the slot at index 0 is always accepted, so any stream of operations drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grp_valid_i | input | GRP_SLOTS | Slot holds an instruction |
| grp_mem_i | input | GRP_SLOTS | Slot is a memory operation |
| grp_hint_i | input | GRP_SLOTS | Memory slot is hinted independent and skips the predictor |
| accept_o | output | GRP_SLOTS | Slot dispatches this cycle |
| port_grant_o | output | GRP_SLOTS | Slot is given a predictor read port |
| stall_o | output | GRP_SLOTS | Slot is held: set from the first slot that does not fit onward |

## Verification
The bench builds two copies of the block, both with four slots. The first uses two read ports and the second uses one. Both are swept over all 4096 combinations of the valid, memory and hint bits. Running two port counts over every group shape reaches these cases:

- the hold starting at each slot position;
- hinted and non-memory slots sitting in front of, between and behind the overflowing slot;
- invalid slots inside the group.

A short operation stream is then re-presented cycle by cycle to confirm the per-cycle accept counts and the forward progress of held slots.

// File: rtl/mdp_lim_pkg.sv
package mdp_lim_pkg;

    // One dispatch slot as seen by the limiter.
    typedef struct packed {
        logic valid;
        logic mem;
        logic hint;
    } slot_t;

    // A slot draws a predictor read port only if it is a valid,
    // unhinted memory operation.
    function automatic logic slot_needs_port(slot_t s);
        return s.valid & s.mem & ~s.hint;
    endfunction

endpackage

// File: rtl/mdp_slot_classify.sv
module mdp_slot_classify
    import mdp_lim_pkg::*;
#(
    parameter int GRP_SLOTS = 4
) (
    input  logic [GRP_SLOTS-1:0] valid_i,
    input  logic [GRP_SLOTS-1:0] mem_i,
    input  logic [GRP_SLOTS-1:0] hint_i,
    output logic [GRP_SLOTS-1:0] needs_port_o
);

    slot_t slots [GRP_SLOTS];

    for (genvar g = 0; g < GRP_SLOTS; g++) begin : g_slot
        assign slots[g]        = '{valid: valid_i[g], mem: mem_i[g], hint: hint_i[g]};
        assign needs_port_o[g] = slot_needs_port(slots[g]);

        // R4: hinted or non-memory slots never request a port
        always_comb begin
            p_no_port_for_free_r4: assert (!(needs_port_o[g] && (hint_i[g] || !mem_i[g])))
                else $error("R4: port requested by hinted or non-memory slot %0d", g);
        end
    end

endmodule

// File: rtl/mdp_port_count.sv
module mdp_port_count #(
    parameter int GRP_SLOTS = 4,
    parameter int RD_PORTS  = 2,
    localparam int CW       = $clog2(GRP_SLOTS + 1)
) (
    input  logic [GRP_SLOTS-1:0] needs_port_i,
    output logic [GRP_SLOTS-1:0] overflow_o
);

    // Running count of port requests, from the oldest slot up to and
    // including slot g.
    logic [CW-1:0] run_cnt [GRP_SLOTS];

    for (genvar g = 0; g < GRP_SLOTS; g++) begin : g_cnt
        if (g == 0) begin : g_first
            assign run_cnt[g] = CW'(needs_port_i[g]);
        end else begin : g_rest
            assign run_cnt[g] = run_cnt[g-1] + CW'(needs_port_i[g]);
        end
        assign overflow_o[g] = needs_port_i[g] && (int'(run_cnt[g]) > RD_PORTS);
    end

endmodule

// File: rtl/mdp_hold_mask.sv
module mdp_hold_mask #(
    parameter int GRP_SLOTS = 4
) (
    input  logic [GRP_SLOTS-1:0] overflow_i,
    output logic [GRP_SLOTS-1:0] hold_o
);

    // Once any slot overflows, it and every younger slot are held.
    for (genvar g = 0; g < GRP_SLOTS; g++) begin : g_hold
        if (g == 0) begin : g_first
            assign hold_o[g] = overflow_i[g];
        end else begin : g_rest
            assign hold_o[g] = hold_o[g-1] | overflow_i[g];
        end
    end

endmodule

// File: rtl/mdp_port_limiter.sv
module mdp_port_limiter
    import mdp_lim_pkg::*;
#(
    parameter int GRP_SLOTS = 4,
    parameter int RD_PORTS  = 2
) (
    input  logic [GRP_SLOTS-1:0] grp_valid_i,
    input  logic [GRP_SLOTS-1:0] grp_mem_i,
    input  logic [GRP_SLOTS-1:0] grp_hint_i,
    output logic [GRP_SLOTS-1:0] accept_o,
    output logic [GRP_SLOTS-1:0] port_grant_o,
    output logic [GRP_SLOTS-1:0] stall_o
);

    logic [GRP_SLOTS-1:0] needs_port;
    logic [GRP_SLOTS-1:0] overflow;

    mdp_slot_classify #(.GRP_SLOTS(GRP_SLOTS)) u_classify (
        .valid_i      (grp_valid_i),
        .mem_i        (grp_mem_i),
        .hint_i       (grp_hint_i),
        .needs_port_o (needs_port)
    );

    mdp_port_count #(.GRP_SLOTS(GRP_SLOTS), .RD_PORTS(RD_PORTS)) u_count (
        .needs_port_i (needs_port),
        .overflow_o   (overflow)
    );

    mdp_hold_mask #(.GRP_SLOTS(GRP_SLOTS)) u_hold (
        .overflow_i (overflow),
        .hold_o     (stall_o)
    );

    assign accept_o     = grp_valid_i & ~stall_o;
    assign port_grant_o = needs_port & ~stall_o;

    // R2: port budget never exceeded
    always_comb begin
        p_port_budget_r2: assert ($countones(port_grant_o) <= RD_PORTS)
            else $error("R2: %0d ports granted", $countones(port_grant_o));
    end

    // R3: a grant only goes to an accepted, unhinted memory slot
    always_comb begin
        p_grant_accepted_r3: assert ((port_grant_o & ~(accept_o & grp_mem_i & ~grp_hint_i)) == '0)
            else $error("R3: grant to ineligible slot");
    end

    // R8: the oldest valid slot always makes progress
    always_comb begin
        p_oldest_moves_r8: assert (!grp_valid_i[0] || accept_o[0])
            else $error("R8: oldest slot held");
    end

    for (genvar g = 1; g < GRP_SLOTS; g++) begin : g_chk
        // R5: the hold extends to every younger slot
        always_comb begin
            p_hold_spreads_r5: assert (!stall_o[g-1] || stall_o[g])
                else $error("R5: hold gap at slot %0d", g);
        end
        // R4: the first held slot is always a port-needing slot
        always_comb begin
            p_hold_starts_on_port_r4: assert (!(stall_o[g] && !stall_o[g-1]) || needs_port[g])
                else $error("R4: hold begins at free slot %0d", g);
        end
    end

endmodule

// File: tb/tb_mdp_port_limiter.sv
module tb_mdp_port_limiter;

    localparam int NS = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic [NS-1:0] v, m, h;
    logic [NS-1:0] acc2, gnt2, stl2;
    logic [NS-1:0] acc1, gnt1, stl1;

    int n_chk  = 0;
    int n_fail = 0;

    mdp_port_limiter #(.GRP_SLOTS(NS), .RD_PORTS(2)) dut (
        .grp_valid_i(v), .grp_mem_i(m), .grp_hint_i(h),
        .accept_o(acc2), .port_grant_o(gnt2), .stall_o(stl2)
    );

    mdp_port_limiter #(.GRP_SLOTS(NS), .RD_PORTS(1)) dut_one_port (
        .grp_valid_i(v), .grp_mem_i(m), .grp_hint_i(h),
        .accept_o(acc1), .port_grant_o(gnt1), .stall_o(stl1)
    );

    task automatic check(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (v=%b m=%b h=%b)", req, act, exp, v, m, h);
        end
    endtask

    // Expected outputs derived from R5/R6/R3.
    task automatic expect_for(int ports, output logic [NS-1:0] ea,
                              output logic [NS-1:0] eg, output logic [NS-1:0] es);
        int used = 0;
        bit held = 0;
        ea = '0; eg = '0; es = '0;
        for (int i = 0; i < NS; i++) begin
            bit need = v[i] && m[i] && !h[i];
            if (need && !held) begin
                used++;
                if (used > ports) held = 1;
            end
            es[i] = held;
            ea[i] = v[i] && !held;
            eg[i] = need && !held;
        end
    endtask

    task automatic apply(logic [NS-1:0] vv, logic [NS-1:0] mm, logic [NS-1:0] hh);
        @(negedge clk);
        v = vv; m = mm; h = hh;
        #1;
    endtask

    task automatic check_both(string tag);
        logic [NS-1:0] ea, eg, es;
        expect_for(2, ea, eg, es);
        check({tag, " R6 accept p2"}, acc2, ea);
        check({tag, " R3 grant p2"}, gnt2, eg);
        check({tag, " R5 stall p2"}, stl2, es);
        expect_for(1, ea, eg, es);
        check({tag, " R6 accept p1"}, acc1, ea);
        check({tag, " R3 grant p1"}, gnt1, eg);
        check({tag, " R5 stall p1"}, stl1, es);
    endtask

    // Stream of ops for R8: 0=unhinted mem, 1=hinted mem, 2=non-mem
    int stream [10] = '{0, 0, 0, 1, 2, 0, 0, 0, 0, 1};
    int exp_acc [4] = '{2, 4, 2, 2};
    int exp_gnt [4] = '{2, 2, 2, 1};

    initial begin
        v = '0; m = '0; h = '0;
        #1;
        // Reset state / empty group (R1)
        check("R1 empty accept", acc2, '0);
        check("R1 empty stall", stl2, '0);
        check("R1 empty grant", gnt2, '0);

        // R1: no port-needing slots
        apply(4'b1111, 4'b0000, 4'b0000);
        check("R1 nonmem accept", acc2, 4'b1111);
        check("R1 nonmem stall", stl2, 4'b0000);
        apply(4'b1111, 4'b1111, 4'b1111);
        check("R4 all hinted accept p1", acc1, 4'b1111);
        check("R4 all hinted grant p1", gnt1, 4'b0000);

        // R5: third unhinted mem at slot 3 with hinted between
        apply(4'b1111, 4'b1111, 4'b0100);
        check("R5 hold at slot3", stl2, 4'b1000);
        check("R2 two grants", gnt2, 4'b0011);

        // Exhaustive sweep (R2..R6)
        for (int k = 0; k < 4096; k++) begin
            apply(k[3:0], k[7:4], k[11:8]);
            check_both("sweep");
        end

        // R7: same group after a different group gives same result
        apply(4'b1111, 4'b1111, 4'b0000);
        apply(4'b1111, 4'b0000, 4'b0000);
        apply(4'b1111, 4'b1111, 4'b0000);
        check("R7 repeat accept", acc2, 4'b0011);
        check("R7 repeat stall", stl2, 4'b1100);

        // R8: re-presented stream, oldest held slot moves to index 0
        begin
            int ptr = 0;
            int cyc = 0;
            while (ptr < 10 && cyc < 10) begin
                logic [NS-1:0] vv, mm, hh;
                int na;
                for (int i = 0; i < NS; i++) begin
                    vv[i] = (ptr + i) < 10;
                    mm[i] = vv[i] && stream[(ptr + i) % 10] != 2;
                    hh[i] = vv[i] && stream[(ptr + i) % 10] == 1;
                end
                apply(vv, mm, hh);
                na = $countones(acc2);
                n_chk++;
                if (na != exp_acc[cyc] || !acc2[0]) begin
                    n_fail++;
                    $display("FAIL R8 cycle %0d: actual accepts %0d expected %0d", cyc, na, exp_acc[cyc]);
                end
                n_chk++;
                if ($countones(gnt2) != exp_gnt[cyc]) begin
                    n_fail++;
                    $display("FAIL R8 grants cycle %0d: actual %0d expected %0d",
                             cyc, $countones(gnt2), exp_gnt[cyc]);
                end
                ptr += na;
                cyc++;
            end
            n_chk++;
            if (cyc != 4) begin
                n_fail++;
                $display("FAIL R8 drain cycles: actual %0d expected 4", cyc);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule